// File: doc/BRIEF.md
# Dual-Direction Processor Mailbox

This block links two processors, called side A and side B, through a pair of small word-wide queues, one for each direction. A word that side A writes goes into the queue that side B drains. A word that side B writes goes into the queue that side A drains. Each side has its own register view. It writes words through a write strobe and data bus, and it reads the oldest incoming word through a read bus. A read strobe pops that word. Each side also has a four-bit status vector and a status-write strobe.

Each side has one interrupt line. The line is high while an incoming word is waiting, or while one of that side's two error flags is set. The error flags are a write-overflow flag and a read-on-empty flag. Both are sticky: a side clears its own two flags by pulsing its status-write strobe.

Software on a side uses the block as follows:

- Reading a word is enough to acknowledge a data interrupt. The line drops once the last waiting word has been taken.
- Only the error conditions need an explicit status write to clear them.

Top module: `mbx_pair`

## Requirements
- R1: After reset both queues are empty and all four error flags are clear. Each side's status reads 4'b0010, with only the space-available bit set, and both interrupt lines are low.
- R2: A pulse on one side's write strobe appends the word to the queue that the opposite side reads. Each queue holds 8 words of 32 bits and delivers them in arrival order. While a side has a word waiting, its read bus shows the oldest word combinationally. A read strobe removes that word at the clock edge.
- R3: The status bits are defined as follows. Bit 0 is set when the incoming queue holds at least one word. Bit 1 is set when the outgoing queue is not full. Bit 2 is the sticky write-overflow flag. Bit 3 is the sticky read-on-empty flag.
- R4: A side's interrupt equals the OR of its status bits 0, 2 and 3. The space-available bit 1 never raises it.
- R5: Taking the last waiting word drops the interrupt in the next cycle, provided no error flag is set. No separate acknowledge is needed.
- R6: A write to a full outgoing queue discards the word and sets the writer's overflow flag. Fullness is judged before the clock edge, so the write is still discarded when the other side pops in the same cycle.
- R7: A read with no incoming word returns zero and leaves the queue unchanged. It also sets the reader's read-on-empty flag.
- R8: Error flags stay set until the owning side pulses its status-write strobe. That pulse clears both of the side's flags and leaves both queues unchanged. An error raised in the same cycle as the pulse remains set.
- R9: The two directions are independent. Traffic, errors or status writes on one side's path do not alter the other direction's queue, or the other side's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_wr_en | input | 1 | Side A write strobe (push toward B) |
| a_wr_data | input | 32 | Side A word to push |
| a_rd_en | input | 1 | Side A read strobe (pop from B's queue) |
| a_rd_data | output | 32 | Oldest word waiting for A, zero when none |
| a_st_wr | input | 1 | Side A status write: clears A's error flags |
| a_status | output | 4 | Side A status {read-on-empty, overflow, space, valid} |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B write strobe (push toward A) |
| b_wr_data | input | 32 | Side B word to push |
| b_rd_en | input | 1 | Side B read strobe (pop from A's queue) |
| b_rd_data | output | 32 | Oldest word waiting for B, zero when none |
| b_st_wr | input | 1 | Side B status write: clears B's error flags |
| b_status | output | 4 | Side B status {read-on-empty, overflow, space, valid} |
| b_irq | output | 1 | Side B interrupt |

## Verification
The block is tried with several traffic patterns, and each one targets a different fault:

- A short burst from A drained by B checks ordering, and checks that the interrupt clears on the last pop without an acknowledge.
- A burst from B that fills A's queue and then writes one more word tells the full boundary apart from the off-by-one depths. A read past empty then shows that pointers and data are not disturbed.
- Cycles that combine a push with a pop, an overflow with a pop on a full queue, and an error with a status write in the same cycle separate the pre-edge full decision and the set-over-clear priority from the alternatives.
- Idle stretches and status writes made while words are queued show that the flags are sticky and that a status write leaves the queues untouched.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ST_VLD = 0;   // incoming word waiting
  localparam int ST_RDY = 1;   // outgoing queue has space
  localparam int ST_WOF = 2;   // sticky write overflow
  localparam int ST_ROE = 3;   // sticky read on empty
  localparam int ST_W   = 4;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  // Full/empty are taken from the registered count, i.e. before the edge.
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_ok) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (pop_ok)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; contents only matter once counted valid.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= push_data;
  end
endmodule

// File: rtl/mbx_side.sv
module mbx_side
  import mbx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            out_full,
  input  logic            rd_en,
  input  logic            in_empty,
  input  logic [W-1:0]    in_head,
  input  logic            st_wr,
  output logic [W-1:0]    rd_data,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic wof_q, wof_d, roe_q, roe_d;

  // Set has priority over the status-write clear.
  always_comb begin
    wof_d = (st_wr ? 1'b0 : wof_q) | (wr_en & out_full);
    roe_d = (st_wr ? 1'b0 : roe_q) | (rd_en & in_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wof_q <= 1'b0;
      roe_q <= 1'b0;
    end else begin
      wof_q <= wof_d;
      roe_q <= roe_d;
    end
  end

  always_comb begin
    status         = '0;
    status[ST_VLD] = !in_empty;
    status[ST_RDY] = !out_full;
    status[ST_WOF] = wof_q;
    status[ST_ROE] = roe_q;
  end

  assign rd_data = in_empty ? '0 : in_head;
  assign irq     = !in_empty | wof_q | roe_q;
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              a_wr_en,
  input  logic [DATA_W-1:0] a_wr_data,
  input  logic              a_rd_en,
  output logic [DATA_W-1:0] a_rd_data,
  input  logic              a_st_wr,
  output logic [ST_W-1:0]   a_status,
  output logic              a_irq,
  input  logic              b_wr_en,
  input  logic [DATA_W-1:0] b_wr_data,
  input  logic              b_rd_en,
  output logic [DATA_W-1:0] b_rd_data,
  input  logic              b_st_wr,
  output logic [ST_W-1:0]   b_status,
  output logic              b_irq
);
  localparam int NSIDE = 2;

  logic              rst_n_sync;
  logic [NSIDE-1:0]  wr_en_v, rd_en_v, st_wr_v, full_v, empty_v, irq_v;
  logic [DATA_W-1:0] wr_data_v [NSIDE];
  logic [DATA_W-1:0] head_v    [NSIDE];
  logic [DATA_W-1:0] rd_data_v [NSIDE];
  logic [ST_W-1:0]   status_v  [NSIDE];

  mbx_rst_sync u_rst (
    .clk       (clk),
    .arst_n    (arst_n),
    .rst_n_out (rst_n_sync)
  );

  assign wr_en_v      = {b_wr_en, a_wr_en};
  assign rd_en_v      = {b_rd_en, a_rd_en};
  assign st_wr_v      = {b_st_wr, a_st_wr};
  assign wr_data_v[0] = a_wr_data;
  assign wr_data_v[1] = b_wr_data;

  // Queue s carries words written by side s toward side 1-s.
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    mbx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n_sync),
      .push      (wr_en_v[s]),
      .push_data (wr_data_v[s]),
      .pop       (rd_en_v[1-s]),
      .head      (head_v[s]),
      .empty     (empty_v[s]),
      .full      (full_v[s])
    );

    mbx_side #(.W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .wr_en    (wr_en_v[s]),
      .out_full (full_v[s]),
      .rd_en    (rd_en_v[s]),
      .in_empty (empty_v[1-s]),
      .in_head  (head_v[1-s]),
      .st_wr    (st_wr_v[s]),
      .rd_data  (rd_data_v[s]),
      .status   (status_v[s]),
      .irq      (irq_v[s])
    );
  end

  assign a_rd_data = rd_data_v[0];
  assign b_rd_data = rd_data_v[1];
  assign a_status  = status_v[0];
  assign b_status  = status_v[1];
  assign a_irq     = irq_v[0];
  assign b_irq     = irq_v[1];
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_wr_en,
  input logic              a_rd_en,
  input logic [DATA_W-1:0] a_rd_data,
  input logic              a_st_wr,
  input logic [3:0]        a_status,
  input logic              a_irq,
  input logic              b_wr_en,
  input logic              b_rd_en,
  input logic [DATA_W-1:0] b_rd_data,
  input logic              b_st_wr,
  input logic [3:0]        b_status,
  input logic              b_irq
);
  AST_A_WOF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr_en && !a_status[1]) |=> a_status[2]);                        // R6
  AST_B_WOF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (b_wr_en && !b_status[1]) |=> b_status[2]);                        // R6
  AST_A_ROE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd_en && !a_status[0]) |=> a_status[3]);                        // R7
  AST_B_ROE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rd_en && !b_status[0]) |-> (b_rd_data == '0));                  // R7
  AST_A_ROE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd_en && !a_status[0]) |-> (a_rd_data == '0));                  // R7
  AST_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (a_status[2] && !a_st_wr) |=> a_status[2]);                        // R8
  AST_B_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (b_st_wr && !b_wr_en && !b_rd_en) |=> (!b_status[2] && !b_status[3])); // R8
  AST_A_RDY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_status[0] && !a_status[2] && !a_status[3]) |-> !a_irq);        // R4
  AST_B_IRQ_ON_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    b_status[0] |-> b_irq);                                            // R4
  AST_A_LAST_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd_en && a_status[0] && !b_wr_en && !a_status[2] && !a_status[3] && !a_st_wr)
      |=> (!a_status[0] || a_irq));                                    // R5
endmodule

bind mbx_pair mbx_pair_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .a_wr_en   (a_wr_en),
  .a_rd_en   (a_rd_en),
  .a_rd_data (a_rd_data),
  .a_st_wr   (a_st_wr),
  .a_status  (a_status),
  .a_irq     (a_irq),
  .b_wr_en   (b_wr_en),
  .b_rd_en   (b_rd_en),
  .b_rd_data (b_rd_data),
  .b_st_wr   (b_st_wr),
  .b_status  (b_status),
  .b_irq     (b_irq)
);

// File: tb/mbx_pair_tb_top.sv
module mbx_pair_tb_top;
  localparam int DW    = 32;
  localparam int DEPTH = 8;

  logic          clk;
  logic          arst_n;
  logic          a_wr_en, a_rd_en, a_st_wr, b_wr_en, b_rd_en, b_st_wr;
  logic [DW-1:0] a_wr_data, b_wr_data, a_rd_data, b_rd_data;
  logic [3:0]    a_status, b_status;
  logic          a_irq, b_irq;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  // Scoreboard model: expected queue contents per direction and error flags.
  logic [DW-1:0] q_ab[$];
  logic [DW-1:0] q_ba[$];
  bit wof_a, roe_a, wof_b, roe_b;

  mbx_pair #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .arst_n(arst_n),
    .a_wr_en(a_wr_en), .a_wr_data(a_wr_data), .a_rd_en(a_rd_en),
    .a_rd_data(a_rd_data), .a_st_wr(a_st_wr), .a_status(a_status), .a_irq(a_irq),
    .b_wr_en(b_wr_en), .b_wr_data(b_wr_data), .b_rd_en(b_rd_en),
    .b_rd_data(b_rd_data), .b_st_wr(b_st_wr), .b_status(b_status), .b_irq(b_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_status(input string tag);
    logic [3:0] ea, eb;
    ea = {roe_a, wof_a, q_ab.size() < DEPTH, q_ba.size() > 0};
    eb = {roe_b, wof_b, q_ba.size() < DEPTH, q_ab.size() > 0};
    check(a_status == ea, {tag, " R3 side A status"}, 64'(a_status), 64'(ea));
    check(b_status == eb, {tag, " R3 side B status"}, 64'(b_status), 64'(eb));
    check(a_irq == (ea[0] | ea[2] | ea[3]), {tag, " R4 side A irq"},
          64'(a_irq), 64'(ea[0] | ea[2] | ea[3]));
    check(b_irq == (eb[0] | eb[2] | eb[3]), {tag, " R4 side B irq"},
          64'(b_irq), 64'(eb[0] | eb[2] | eb[3]));
  endtask

  // Driver and monitor for one cycle, entered and left at a falling edge.
  task automatic step(input bit aw, input logic [DW-1:0] ad, input bit ar, input bit asw,
                      input bit bw, input logic [DW-1:0] bd, input bit br, input bit bsw,
                      input string tag);
    int n_ab, n_ba;
    logic [DW-1:0] exp;
    n_ab = q_ab.size();
    n_ba = q_ba.size();
    a_wr_en = aw; a_wr_data = ad; a_rd_en = ar; a_st_wr = asw;
    b_wr_en = bw; b_wr_data = bd; b_rd_en = br; b_st_wr = bsw;
    #1;
    if (ar) begin
      exp = (n_ba > 0) ? q_ba[0] : '0;
      check(a_rd_data == exp, {tag, " R2 side A read data"}, 64'(a_rd_data), 64'(exp));
    end
    if (br) begin
      exp = (n_ab > 0) ? q_ab[0] : '0;
      check(b_rd_data == exp, {tag, " R2 side B read data"}, 64'(b_rd_data), 64'(exp));
    end
    if (ar && n_ba > 0) void'(q_ba.pop_front());
    if (br && n_ab > 0) void'(q_ab.pop_front());
    if (aw && n_ab < DEPTH) q_ab.push_back(ad);
    if (bw && n_ba < DEPTH) q_ba.push_back(bd);
    wof_a = (asw ? 1'b0 : wof_a) | (aw && n_ab == DEPTH);
    roe_a = (asw ? 1'b0 : roe_a) | (ar && n_ba == 0);
    wof_b = (bsw ? 1'b0 : wof_b) | (bw && n_ba == DEPTH);
    roe_b = (bsw ? 1'b0 : roe_b) | (br && n_ab == 0);
    @(negedge clk);
    a_wr_en = 0; a_rd_en = 0; a_st_wr = 0;
    b_wr_en = 0; b_rd_en = 0; b_st_wr = 0;
    #1;
    check_status(tag);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run hung actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    a_wr_en = 0; a_rd_en = 0; a_st_wr = 0; a_wr_data = '0;
    b_wr_en = 0; b_rd_en = 0; b_st_wr = 0; b_wr_data = '0;
    arst_n = 0;
    repeat (3) @(negedge clk);
    arst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    check(a_status == 4'b0010, "R1 side A status", 64'(a_status), 64'h2);
    check(b_status == 4'b0010, "R1 side B status", 64'(b_status), 64'h2);
    check(!a_irq && !b_irq, "R1 irq low", 64'({a_irq, b_irq}), 64'h0);
    @(negedge clk);

    // R2/R9: short burst A to B, B drains it in order; R5 irq drops on last pop
    for (int i = 0; i < 3; i++) step(1, 32'hA000_0000 + i, 0, 0, 0, '0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, '0, 0, 0, 0, '0, 1, 0, "R5");

    // R6: fill B to A queue, one more write overflows, pop in same cycle on full
    for (int i = 0; i < DEPTH; i++) step(0, '0, 0, 0, 1, 32'hB000_0010 + i, 0, 0, "R2");
    step(0, '0, 0, 0, 1, 32'hDEAD_BEEF, 0, 0, "R6");
    step(0, '0, 0, 0, 0, '0, 0, 1, "R8");
    step(0, '0, 1, 0, 1, 32'hDEAD_0001, 0, 0, "R6");
    // R9: A side idles its own status write; B's flag untouched
    step(0, '0, 0, 1, 0, '0, 0, 0, "R9");
    for (int i = 0; i < DEPTH - 1; i++) step(0, '0, 1, 0, 0, '0, 0, 0, "R2");

    // R7: read past empty returns zero, sets flag, queue stays empty
    step(0, '0, 1, 0, 0, '0, 0, 0, "R7");
    step(0, '0, 1, 0, 0, '0, 0, 0, "R7");
    // R8: sticky over idle cycles
    for (int i = 0; i < 3; i++) step(0, '0, 0, 0, 0, '0, 0, 0, "R8");
    // R8: status write with words queued keeps queues intact
    step(1, 32'h1111_2222, 0, 0, 0, '0, 0, 0, "R8");
    step(1, 32'h3333_4444, 0, 1, 0, '0, 0, 1, "R8");
    // R8: error in the same cycle as the status write stays set
    step(0, '0, 1, 1, 0, '0, 0, 0, "R8");
    step(0, '0, 0, 1, 0, '0, 0, 0, "R8");
    // R2: push and pop on the same queue in one cycle
    step(1, 32'h5555_6666, 0, 0, 0, '0, 1, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, '0, 0, 0, 0, '0, 1, 0, "R5");
    step(0, '0, 0, 0, 0, '0, 1, 0, "R7");
    step(0, '0, 0, 0, 0, '0, 0, 1, "R8");

    done = 1;
    summary();
    $finish;
  end
endmodule